// File: doc/BRIEF.md
# Packet Router Datapath Register

This unit is the byte datapath of a single-input packet router. A controller steps it through a packet with one-hot style phase strobes. The unit presents on its 8-bit output the byte bound for the output buffers: the header, the payload bytes, the trailing parity byte, or a byte that was parked while the chosen buffer was full. The output register holds its value in every cycle in which no source is selected.

Alongside the datapath it accumulates an XOR check value over the header and payload. When the packet's own parity byte is loaded, the unit compares the two one cycle later and raises a sticky mismatch flag. Two status flags report facts about the packet to the controller: the sender has dropped its valid line, and the parity stage has been reached. The controller uses them to decide where to resume after a stall. A per-packet clear strobe wipes the flags, the check value and the mismatch flag.

Top module: `pkt_datapath_reg`

## Requirements
- R1: While rst_ni is low, dout_o, err_o, par_done_o and pv_low_o are all 0, and all internal registers are cleared.
- R2: The header register loads data_i at a clock edge where hdr_det_i and pkt_valid_i are both 1, and only then. A cycle with first_ld_i high drives the header register onto dout_o at that edge.
- R3: dout_o is loaded at each edge from the highest-priority active source. The order is: header (first_ld_i), then payload (pay_ld_i=1 with fifo_full_i=0), then parity byte (par_ld_i=1 with fifo_full_i=0), then side register (resume_i). With no source active, dout_o holds its value.
- R4: The side register loads data_i when stall_i and fifo_full_i are both 1. When resume_i selects the side register, dout_o shows the value the side register held before that edge.
- R5: par_done_o is set after an edge where pay_ld_i=1, fifo_full_i=0 and pkt_valid_i=0. It is also set after an edge where resume_i=1, pv_low_o=1 and par_done_o=0. It stays set until cleared.
- R6: pv_low_o is set after an edge where pay_ld_i=1 and pkt_valid_i=0. clr_i=1 clears both status flags at the next edge, and the clear wins over any set in the same cycle.
- R7: A byte loaded through the parity source is captured as the packet parity. At the following edge, err_o is set if the check value differs from it. A clr_i in either of those cycles cancels the comparison.
- R8: The check value starts at 0 and is cleared by clr_i. It takes the XOR of each byte loaded onto dout_o from the header, from payload while pkt_valid_i=1, or from the side register while pv_low_o=0. err_o, once set, stays 1 until clr_i or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Incoming packet byte |
| pkt_valid_i | input | 1 | Sender marks packet bytes valid |
| fifo_full_i | input | 1 | Selected output buffer is full |
| hdr_det_i | input | 1 | Controller is in address-decode phase |
| first_ld_i | input | 1 | Drive captured header onto dout_o |
| pay_ld_i | input | 1 | Payload load phase |
| resume_i | input | 1 | Load-after-stall phase, drive side register |
| stall_i | input | 1 | Buffer-full wait phase |
| par_ld_i | input | 1 | Parity byte load phase |
| clr_i | input | 1 | Per-packet clear of flags, check value and error |
| dout_o | output | 8 | Byte toward the output buffers |
| err_o | output | 1 | Sticky parity mismatch |
| par_done_o | output | 1 | Parity stage reached |
| pv_low_o | output | 1 | Sender valid has been dropped |

## Verification
Two pairs of functions can land in one cycle. The first is a status-flag set together with the per-packet clear. The second is a pending parity comparison together with that clear. Both fall in the same cycle when random phase strobes are mixed with a frequent clear. A directed case also issues a clear on the cycle right after a mismatching parity byte; err_o must stay 0 and both flags must read 0. The bench runs a reference model built from the requirements, so the clear-wins rule is judged at every edge on all four outputs.

// File: rtl/pkt_datapath_reg_pkg.sv
package pkt_datapath_reg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_HDR  = 3'd1,
    SRC_PAY  = 3'd2,
    SRC_PAR  = 3'd3,
    SRC_SIDE = 3'd4
  } src_e;
endpackage

// File: rtl/pdr_capture.sv
module pdr_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         hdr_we_i,
  input  logic         side_we_i,
  output logic [W-1:0] hdr_o,
  output logic [W-1:0] side_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_o  <= '0;
      side_o <= '0;
    end else begin
      if (hdr_we_i)  hdr_o  <= data_i;
      if (side_we_i) side_o <= data_i;
    end
  end
endmodule

// File: rtl/pdr_out_sel.sv
module pdr_out_sel
  import pkt_datapath_reg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] hdr_i,
  input  logic [W-1:0] side_i,
  input  logic         fifo_full_i,
  input  logic         first_ld_i,
  input  logic         pay_ld_i,
  input  logic         par_ld_i,
  input  logic         resume_i,
  output src_e         src_o,
  output logic [W-1:0] byte_o,
  output logic [W-1:0] dout_o
);
  always_comb begin
    if (first_ld_i)                   src_o = SRC_HDR;
    else if (pay_ld_i && !fifo_full_i) src_o = SRC_PAY;
    else if (par_ld_i && !fifo_full_i) src_o = SRC_PAR;
    else if (resume_i)                src_o = SRC_SIDE;
    else                              src_o = SRC_HOLD;
  end

  always_comb begin
    unique case (src_o)
      SRC_HDR:          byte_o = hdr_i;
      SRC_PAY, SRC_PAR: byte_o = data_i;
      SRC_SIDE:         byte_o = side_i;
      default:          byte_o = dout_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               dout_o <= '0;
    else if (src_o != SRC_HOLD) dout_o <= byte_o;
  end
endmodule

// File: rtl/pdr_parity.sv
module pdr_parity #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         acc_en_i,
  input  logic         par_cap_i,
  input  logic [W-1:0] byte_i,
  output logic         err_o
);
  logic [W-1:0] acc_q, par_q;
  logic         chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      par_q <= '0;
      chk_q <= 1'b0;
      err_o <= 1'b0;
    end else begin
      if (par_cap_i) par_q <= byte_i;
      if (clr_i) begin
        acc_q <= '0;
        chk_q <= 1'b0;
        err_o <= 1'b0;
      end else begin
        if (acc_en_i) acc_q <= acc_q ^ byte_i;
        chk_q <= par_cap_i;
        // compare one cycle after the parity byte was taken
        if (chk_q && (acc_q != par_q)) err_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdr_status.sv
module pdr_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic pay_ld_i,
  input  logic resume_i,
  input  logic fifo_full_i,
  input  logic pkt_valid_i,
  output logic par_done_o,
  output logic pv_low_o
);
  logic done_set, low_set;

  assign done_set = (pay_ld_i && !fifo_full_i && !pkt_valid_i) ||
                    (resume_i && pv_low_o && !par_done_o);
  assign low_set  = pay_ld_i && !pkt_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_done_o <= 1'b0;
      pv_low_o   <= 1'b0;
    end else if (clr_i) begin
      par_done_o <= 1'b0;
      pv_low_o   <= 1'b0;
    end else begin
      if (done_set) par_done_o <= 1'b1;
      if (low_set)  pv_low_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/pkt_datapath_reg.sv
module pkt_datapath_reg
  import pkt_datapath_reg_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         pkt_valid_i,
  input  logic         fifo_full_i,
  input  logic         hdr_det_i,
  input  logic         first_ld_i,
  input  logic         pay_ld_i,
  input  logic         resume_i,
  input  logic         stall_i,
  input  logic         par_ld_i,
  input  logic         clr_i,
  output logic [W-1:0] dout_o,
  output logic         err_o,
  output logic         par_done_o,
  output logic         pv_low_o
);
  logic [W-1:0] hdr_q, side_q, sel_byte;
  src_e         src;
  logic         acc_en;

  pdr_capture #(.W(W)) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .hdr_we_i  (hdr_det_i && pkt_valid_i),
    .side_we_i (stall_i && fifo_full_i),
    .hdr_o     (hdr_q),
    .side_o    (side_q)
  );

  pdr_out_sel #(.W(W)) u_out_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_i      (data_i),
    .hdr_i       (hdr_q),
    .side_i      (side_q),
    .fifo_full_i (fifo_full_i),
    .first_ld_i  (first_ld_i),
    .pay_ld_i    (pay_ld_i),
    .par_ld_i    (par_ld_i),
    .resume_i    (resume_i),
    .src_o       (src),
    .byte_o      (sel_byte),
    .dout_o      (dout_o)
  );

  // parity byte and post-valid bytes stay out of the check value
  assign acc_en = (src == SRC_HDR) ||
                  (src == SRC_PAY && pkt_valid_i) ||
                  (src == SRC_SIDE && !pv_low_o);

  pdr_parity #(.W(W)) u_parity (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .acc_en_i  (acc_en),
    .par_cap_i (src == SRC_PAR),
    .byte_i    (sel_byte),
    .err_o     (err_o)
  );

  pdr_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .pay_ld_i    (pay_ld_i),
    .resume_i    (resume_i),
    .fifo_full_i (fifo_full_i),
    .pkt_valid_i (pkt_valid_i),
    .par_done_o  (par_done_o),
    .pv_low_o    (pv_low_o)
  );
endmodule

// File: rtl/pkt_datapath_reg_chk.sv
module pkt_datapath_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] data_i,
  input logic         pkt_valid_i,
  input logic         fifo_full_i,
  input logic         hdr_det_i,
  input logic         first_ld_i,
  input logic         pay_ld_i,
  input logic         resume_i,
  input logic         stall_i,
  input logic         par_ld_i,
  input logic         clr_i,
  input logic [W-1:0] dout_o,
  input logic         err_o,
  input logic         par_done_o,
  input logic         pv_low_o
);
  // R2
  hdr_to_dout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_det_i && pkt_valid_i) ##1 (first_ld_i && !(hdr_det_i && pkt_valid_i))
    |=> dout_o == $past(data_i, 2));

  // R3
  payload_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_ld_i && !fifo_full_i && !first_ld_i) |=> dout_o == $past(data_i));

  // R3
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!first_ld_i && !(pay_ld_i && !fifo_full_i) && !(par_ld_i && !fifo_full_i) && !resume_i)
    |=> $stable(dout_o));

  // R4
  side_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && fifo_full_i) ##1
    (resume_i && !first_ld_i && !(pay_ld_i && !fifo_full_i) && !(par_ld_i && !fifo_full_i))
    |=> dout_o == $past(data_i, 2));

  // R5
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_ld_i && !fifo_full_i && !pkt_valid_i && !clr_i) |=> par_done_o);

  // R6
  low_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_ld_i && !pkt_valid_i && !clr_i) |=> pv_low_o);

  // R6
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!par_done_o && !pv_low_o && !err_o));

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);
endmodule

bind pkt_datapath_reg pkt_datapath_reg_chk #(.W(W)) i_chk (.*);

// File: tb/test_pkt_datapath_reg.sv
`timescale 1ns/1ps
module test_pkt_datapath_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] d = '0;
  logic       pv = 0, full = 0, det = 0, fl = 0, ld = 0, rs = 0, st = 0, pl = 0, clr = 0;
  logic [7:0] dout;
  logic       err, pdone, pvlow;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_dout, m_hdr, m_side, m_acc, m_pb;
  logic       m_err, m_pdone, m_pvl, m_chk;

  always #5 clk = ~clk;

  pkt_datapath_reg i_pkt_datapath_reg (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d), .pkt_valid_i(pv), .fifo_full_i(full),
    .hdr_det_i(det), .first_ld_i(fl), .pay_ld_i(ld), .resume_i(rs), .stall_i(st),
    .par_ld_i(pl), .clr_i(clr), .dout_o(dout), .err_o(err),
    .par_done_o(pdone), .pv_low_o(pvlow));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_dout = 0; m_hdr = 0; m_side = 0; m_acc = 0; m_pb = 0;
    m_err = 0; m_pdone = 0; m_pvl = 0; m_chk = 0;
  endtask

  function automatic int pick_src();
    if (fl) return 1;
    if (ld && !full) return 2;
    if (pl && !full) return 3;
    if (rs) return 4;
    return 0;
  endfunction

  task automatic m_step();
    int s = pick_src();
    logic [7:0] nb;
    logic inc, n_pdone, n_pvl;
    case (s)
      1: nb = m_hdr;
      2, 3: nb = d;
      4: nb = m_side;
      default: nb = m_dout;
    endcase
    inc = (s == 1) || (s == 2 && pv) || (s == 4 && !m_pvl);
    if (clr) begin
      n_pdone = 0; n_pvl = 0; m_err = 0; m_acc = 0; m_chk = 0;
    end else begin
      n_pdone = m_pdone | (ld && !full && !pv) | (rs && m_pvl && !m_pdone);
      n_pvl   = m_pvl | (ld && !pv);
      if (m_chk && m_acc != m_pb) m_err = 1;
      m_chk = (s == 3);
      if (inc) m_acc = m_acc ^ nb;
    end
    if (s == 3) m_pb = d;
    m_pdone = n_pdone; m_pvl = n_pvl;
    if (s != 0) m_dout = nb;
    if (det && pv) m_hdr = d;
    if (st && full) m_side = d;
  endtask

  task automatic cmp_all();
    chk("R3 dout", dout, m_dout);
    chk("R7 err", {7'd0, err}, {7'd0, m_err});
    chk("R5 par_done", {7'd0, pdone}, {7'd0, m_pdone});
    chk("R6 pv_low", {7'd0, pvlow}, {7'd0, m_pvl});
  endtask

  // drive at negedge, step model at posedge, compare at next negedge
  task automatic cyc(input logic [7:0] di, input logic vpv, vfull, vdet, vfl, vld,
                     vrs, vst, vpl, vclr);
    d = di; pv = vpv; full = vfull; det = vdet; fl = vfl; ld = vld;
    rs = vrs; st = vst; pl = vpl; clr = vclr;
    @(posedge clk);
    m_step();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle();
    cyc(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int unused = $urandom(32'h5EED_0042);
    m_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dout", dout, 8'h00);
    chk("R1 flags", {5'd0, err, pdone, pvlow}, 8'h00);
    rst_n = 1'b1;
    idle();

    // R2 header capture and presentation; R8 good parity
    cyc(8'h5A, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc(8'hFF, 0, 0, 1, 0, 0, 0, 0, 0, 0);   // pv low: no capture
    cyc(8'h00, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R2 header on dout", dout, 8'h5A);
    cyc(8'h11, 1, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3 payload", dout, 8'h11);
    cyc(8'h77, 1, 1, 0, 0, 1, 0, 0, 0, 0);   // full: hold
    chk("R3 hold on full", dout, 8'h11);
    cyc(8'h22, 1, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc(8'h69, 0, 0, 0, 0, 0, 0, 0, 1, 0);   // 5A^11^22
    chk("R7 parity byte on dout", dout, 8'h69);
    idle();
    chk("R8 matching parity no err", {7'd0, err}, 8'h00);
    cyc(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1);

    // R4 side register across a stall
    cyc(8'hC3, 1, 1, 0, 0, 0, 0, 1, 0, 0);
    cyc(8'h3C, 1, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4 side byte on resume", dout, 8'hC3);

    // R5/R6 flags and R7/R8 mismatch
    cyc(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(8'h44, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 par_done set", {7'd0, pdone}, 8'h01);
    chk("R6 pv_low set", {7'd0, pvlow}, 8'h01);
    cyc(8'h01, 0, 0, 0, 0, 0, 0, 0, 1, 0);   // acc=00 vs 01
    idle();
    chk("R7 mismatch err", {7'd0, err}, 8'h01);
    idle();
    chk("R8 err sticky", {7'd0, err}, 8'h01);
    cyc(8'h00, 0, 0, 0, 0, 1, 0, 0, 0, 1);   // set and clear together
    chk("R6 clear wins", {6'd0, pdone, pvlow}, 8'h00);
    chk("R8 clr drops err", {7'd0, err}, 8'h00);
    cyc(8'h09, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1);   // clr cancels compare
    idle();
    chk("R7 clr cancels compare", {7'd0, err}, 8'h00);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r = 4'($urandom);
      cyc(8'($urandom), ($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
          ($urandom % 8) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0,
          ($urandom % 4) == 0, ($urandom % 4) == 0, r == 0);
      if (i == 1500) begin
        rst_n = 1'b0;
        #1;
        m_reset();
        chk("R1 dout mid reset", dout, 8'h00);
        chk("R1 flags mid reset", {5'd0, err, pdone, pvlow}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule